// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by walking a two-level page table in memory, using 4 KiB pages. A translation request carries the logical address. The root base, which is the physical location of the outer table, is taken from an input port in the cycle the request is accepted. The top ten bits of the logical address index the outer table. The next ten bits index the inner-table page that the outer entry points to. The low twelve bits pass through unchanged as the page offset.

The walker owns one memory read port. Requests on that port use a valid/ready handshake, and each response comes back as a single-cycle valid pulse carrying one 32-bit entry. Each entry holds a frame number in bits 31:12 and a valid flag in bit 0. Bits 11:1 of an entry are ignored. A cleared valid flag ends the walk with a fault, and the fault reports the level at which it was found.

The result is held on the output together with a valid flag until the requester acknowledges it. The walker handles one translation at a time.

Top module: `page_walker`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, `mem_req_valid` is 0 and `res_valid` is 0.
- R2: In the cycle after a request is accepted (`req_valid` and `req_ready` both 1 at a clock edge), `mem_req_valid` is 1 and `mem_req_addr` is {root_base[31:12], vaddr[31:22], 2'b00}.
- R3: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the read request and its address are held unchanged.
- R4: An outer entry with bit 0 equal to 0 ends the walk with `res_fault`=1 and `res_level`=0, and no inner read is issued.
- R5: When the outer entry has bit 0 equal to 1, the cycle after its response carries the inner read at {outer[31:12], vaddr[21:12], 2'b00}.
- R6: An inner entry with bit 0 equal to 0 ends the walk with `res_fault`=1 and `res_level`=1.
- R7: A walk with both entries valid reports `res_fault`=0 and `res_paddr` = {inner[31:12], vaddr[11:0]}. Whenever `res_fault` is 1, `res_paddr` reads 0.
- R8: `res_valid` rises in the cycle after the last response of a walk. It then holds, with the result unchanged, until a clock edge at which `res_ack` is 1. In the next cycle `res_valid` is 0 and `req_ready` is 1.
- R9: A `mem_rsp_valid` pulse that arrives while no read is outstanding (idle, or holding a result) changes neither the state nor the result.
- R10: `req_ready` is 0 from the accepting edge until the result is acknowledged. A `req_valid` held high during a walk is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request will be taken |
| req_vaddr | input | 32 | Logical address to translate |
| root_base | input | 32 | Outer table base, 4 KiB aligned, sampled at accept |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Physical address of the entry to read |
| mem_rsp_valid | input | 1 | Read data pulse |
| mem_rsp_data | input | 32 | Entry read from memory |
| res_valid | output | 1 | Translation result held |
| res_ack | input | 1 | Requester takes the result |
| res_paddr | output | 32 | Physical address (0 on fault) |
| res_fault | output | 1 | Walk hit an invalid entry |
| res_level | output | 1 | Fault level: 0 outer, 1 inner |

## Verification
Three results have fixed timing. The outer read appears one cycle after the request is accepted. The inner read appears one cycle after the outer response. The result appears one cycle after the final response and disappears one cycle after the acknowledge edge. The bench keeps a behavioural model that advances on the same clock edges: it watches the handshakes and keeps a queue of expected read addresses. At every falling edge it compares all outputs against the model, so an output that arrives a cycle early or late shows up as a mismatch in that cycle. Memory latency and ready stalls are varied to move these edges, and the expected results depend only on the handshakes.

// File: rtl/page_walker.sv
module page_walker #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10,
  parameter int ENT_W = 32,
  parameter int VLD_BIT = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [PA_W-1:0] root_base,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [PA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [ENT_W-1:0] mem_rsp_data,
  output logic            res_valid,
  input  logic            res_ack,
  output logic [PA_W-1:0] res_paddr,
  output logic            res_fault,
  output logic            res_level
);
  localparam int FN_W = PA_W - OFF_W;
  localparam int SH   = OFF_W - IDX_W;

  typedef enum logic [2:0] {IDLE, OUT_RD, OUT_WT, IN_RD, IN_WT, DONE} st_t;

  st_t             state;
  logic [VA_W-1:0] va_q;
  logic [FN_W-1:0] base_q;
  logic            fault_q, lvl_q;

  logic [FN_W-1:0]  ent_frame;
  logic [IDX_W-1:0] idx_sel;
  logic             ent_ok;
  logic             unused_bits;

  assign ent_frame = mem_rsp_data[ENT_W-1 -: FN_W];
  assign ent_ok    = mem_rsp_data[VLD_BIT];
  assign idx_sel   = (state == IN_RD) ? va_q[OFF_W+IDX_W-1 -: IDX_W] : va_q[VA_W-1 -: IDX_W];
  assign unused_bits = ^{mem_rsp_data[ENT_W-FN_W-1:0], root_base[OFF_W-1:0]};

  assign req_ready     = (state == IDLE);
  assign mem_req_valid = (state == OUT_RD) || (state == IN_RD);
  assign mem_req_addr  = {base_q, idx_sel, {SH{1'b0}}};
  assign res_valid     = (state == DONE);
  assign res_fault     = res_valid && fault_q;
  assign res_level     = res_valid && lvl_q;
  assign res_paddr     = (res_valid && !fault_q) ? {base_q, va_q[OFF_W-1:0]} : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= IDLE;
      va_q    <= '0;
      base_q  <= '0;
      fault_q <= 1'b0;
      lvl_q   <= 1'b0;
    end else begin
      case (state)
        IDLE: if (req_valid) begin
          va_q    <= req_vaddr;
          base_q  <= root_base[PA_W-1:OFF_W];
          fault_q <= 1'b0;
          lvl_q   <= 1'b0;
          state   <= OUT_RD;
        end
        OUT_RD: if (mem_req_ready) state <= OUT_WT;
        OUT_WT: if (mem_rsp_valid) begin
          if (ent_ok) begin
            base_q <= ent_frame;
            state  <= IN_RD;
          end else begin
            fault_q <= 1'b1;
            lvl_q   <= 1'b0;
            state   <= DONE;
          end
        end
        IN_RD: if (mem_req_ready) state <= IN_WT;
        IN_WT: if (mem_rsp_valid) begin
          base_q  <= ent_frame;
          fault_q <= !ent_ok;
          lvl_q   <= !ent_ok;
          state   <= DONE;
        end
        DONE: if (res_ack) state <= IDLE;
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/walker_chk.sv
module walker_chk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_vaddr,
  input logic [PA_W-1:0] root_base,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            res_valid,
  input logic            res_ack,
  input logic [PA_W-1:0] res_paddr,
  input logic            res_fault,
  input logic            res_level
);
  localparam int SH = OFF_W - IDX_W;

  // R2
  outer_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (mem_req_valid &&
      mem_req_addr == {$past(root_base[PA_W-1:OFF_W]), $past(req_vaddr[VA_W-1 -: IDX_W]), {SH{1'b0}}}));

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R8
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ack) |=> (res_valid && $stable(res_paddr) && $stable(res_fault) && $stable(res_level)));

  // R8
  res_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ack) |=> (!res_valid && req_ready));

  // R10
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (!req_ready && !mem_req_valid));

  // R7
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault) |-> (res_paddr == '0));
endmodule

bind page_walker walker_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .root_base(root_base), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr), .res_valid(res_valid),
  .res_ack(res_ack), .res_paddr(res_paddr), .res_fault(res_fault), .res_level(res_level)
);

// File: tb/page_walker_test.sv
module page_walker_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_vaddr = '0, root_base = '0;
  logic        mem_req_valid, mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        res_valid, res_ack = 1'b0, res_fault, res_level;
  logic [31:0] res_paddr;

  page_walker uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .root_base(root_base), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_ack(res_ack), .res_paddr(res_paddr),
    .res_fault(res_fault), .res_level(res_level)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  // memory image and its driver
  logic [31:0] mem [logic [31:0]];
  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  int lat_cfg = 0, rdy_per = 1, cnt = 0;
  bit spur_req = 0, pend = 0, hs_seen = 0, acc_seen = 0;
  logic [31:0] hs_addr = '0, paddr_m = '0;

  always @(posedge clk) begin
    hs_seen  <= mem_req_valid && mem_req_ready;
    hs_addr  <= mem_req_addr;
    acc_seen <= req_valid && req_ready;
  end

  always @(negedge clk) begin
    cyc++;
    mem_rsp_valid = 1'b0;
    if (hs_seen) begin pend = 1; cnt = lat_cfg; paddr_m = hs_addr; end
    if (pend) begin
      if (cnt == 0) begin mem_rsp_valid = 1'b1; mem_rsp_data = rd(paddr_m); pend = 0; end
      else cnt--;
    end else if (spur_req) begin
      mem_rsp_valid = 1'b1; mem_rsp_data = 32'hFFFF_F001; spur_req = 0;
    end
    mem_req_ready = !pend && !mem_rsp_valid && (cyc % rdy_per == 0);
  end

  // behavioural reference model
  logic [31:0] q[$];
  bit m_act = 0, m_out = 0, m_rp = 0, e_f = 0, e_l = 0;
  int m_nrd = 0;
  logic [31:0] e_pa = '0, t_oa, t_ia, t_e1, t_e2;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act <= 0; m_out <= 0; m_rp <= 0; m_nrd <= 0; q.delete();
    end else begin
      if (req_valid && req_ready && !m_act) begin
        t_oa = {root_base[31:12], req_vaddr[31:22], 2'b00};
        t_e1 = rd(t_oa);
        q.push_back(t_oa);
        if (t_e1[0]) begin
          t_ia = {t_e1[31:12], req_vaddr[21:12], 2'b00};
          t_e2 = rd(t_ia);
          q.push_back(t_ia);
          e_f <= !t_e2[0]; e_l <= !t_e2[0];
          e_pa <= t_e2[0] ? {t_e2[31:12], req_vaddr[11:0]} : 32'h0;
        end else begin
          e_f <= 1; e_l <= 0; e_pa <= 32'h0;
        end
        m_act <= 1; m_nrd <= 0;
      end
      if (m_act && mem_req_valid && mem_req_ready && q.size() > 0) begin
        void'(q.pop_front());
        m_out <= 1; m_nrd <= m_nrd + 1;
      end
      if (m_out && mem_rsp_valid) begin
        m_out <= 0;
        if (q.size() == 0) m_rp <= 1;
      end
      if (m_rp && res_ack) begin m_rp <= 0; m_act <= 0; end
    end
  end

  // compare on every clock
  bit exp_mv;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(req_ready == !m_act, "R10", {31'b0, req_ready}, {31'b0, !m_act});
      exp_mv = m_act && !m_out && !m_rp && q.size() > 0;
      chk(mem_req_valid == exp_mv, "R3", {31'b0, mem_req_valid}, {31'b0, exp_mv});
      if (exp_mv)
        chk(mem_req_addr == q[0], (m_nrd == 0) ? "R2" : "R5", mem_req_addr, q[0]);
      chk(res_valid == m_rp, "R8", {31'b0, res_valid}, {31'b0, m_rp});
      if (m_rp) begin
        chk(res_fault == e_f, e_l ? "R6" : (e_f ? "R4" : "R7"), {31'b0, res_fault}, {31'b0, e_f});
        if (e_f) chk(res_level == e_l, e_l ? "R6" : "R4", {31'b0, res_level}, {31'b0, e_l});
        chk(res_paddr == e_pa, "R7", res_paddr, e_pa);
      end
    end
  end

  task automatic map(input logic [31:0] root, input logic [31:0] va, input logic [31:0] itbl,
                     input logic [31:0] frame, input bit ov, input bit iv);
    mem[{root[31:12], va[31:22], 2'b00}] = {itbl[31:12], 11'h2A6, ov};
    mem[{itbl[31:12], va[21:12], 2'b00}] = {frame[31:12], 11'h155, iv};
  endtask

  task automatic walk(input logic [31:0] va, input int ackd, input bit hold, input bit spur_done);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va;
    do @(negedge clk); while (!acc_seen);
    if (hold) req_vaddr = ~va; else req_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    if (spur_done) spur_req = 1;
    repeat (ackd) @(negedge clk);
    if (spur_done) chk(res_valid == 1'b1, "R9", {31'b0, res_valid}, 32'h1);
    res_ack = 1'b1; req_valid = 1'b0;
    @(negedge clk);
    res_ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog: actual=hung expected=walk complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    root_base = 32'h0004_0000;
    map(32'h0004_0000, 32'h1234_5678, 32'h0009_0000, 32'hABCD_E000, 1, 1);
    map(32'h0004_0000, 32'hFFFF_FFFF, 32'h0010_0000, 32'h7777_7000, 1, 1);
    map(32'h0004_0000, 32'h0000_0ABC, 32'h0011_0000, 32'h1111_1000, 0, 1);
    map(32'h0004_0000, 32'h8040_1123, 32'h0012_0000, 32'h2222_2000, 1, 0);
    map(32'h0020_0000, 32'h1234_5678, 32'h0030_0000, 32'h5555_5000, 1, 1);

    repeat (3) @(negedge clk);
    // R1
    chk(req_ready == 1'b1, "R1", {31'b0, req_ready}, 32'h1);
    chk(mem_req_valid == 1'b0, "R1", {31'b0, mem_req_valid}, 32'h0);
    chk(res_valid == 1'b0, "R1", {31'b0, res_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && !res_valid && !mem_req_valid, "R1", {31'b0, req_ready}, 32'h1);

    walk(32'h1234_5678, 0, 0, 0);              // R7 basic hit
    lat_cfg = 3; rdy_per = 3;
    walk(32'hFFFF_FFFF, 2, 0, 0);              // R3 stalls, top indices
    lat_cfg = 0; rdy_per = 1;
    walk(32'h0000_0ABC, 1, 0, 0);              // R4 outer fault
    lat_cfg = 1;
    walk(32'h8040_1123, 0, 0, 0);              // R6 inner fault
    lat_cfg = 0;

    @(negedge clk); spur_req = 1;              // R9 pulse while idle
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R9", {31'b0, req_ready}, 32'h1);
    chk(res_valid == 1'b0, "R9", {31'b0, res_valid}, 32'h0);
    walk(32'h1234_5678, 4, 0, 1);              // R9 pulse while holding result
    walk(32'hFFFF_FFFF, 3, 1, 0);              // R10 request held high
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && !mem_req_valid, "R10", {31'b0, req_ready}, 32'h1);

    @(negedge clk); root_base = 32'h0020_0000;
    rdy_per = 2; lat_cfg = 2;
    walk(32'h1234_5678, 1, 0, 0);              // R2 new root
    repeat (4) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule